// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Flags

This block is the supervision timer of a small 8-bit controller. A counter runs from every restart. If software does not restart it in time, the block sets a sticky timeout flag. The flag drives an interrupt request whenever the interrupt-enable input is high. If software still does not restart the timer within a fixed 512-clock grace window, and the reset-enable bit is set, the block emits a one-clock watchdog reset pulse.

A single 8-bit control/status byte is reached over a plain special-function-register bus. It records why the last reset happened, using separate power-on and watchdog flags that keep or lose their value according to the reset source. The bits that could disarm the watchdog or fake its state sit behind a timed unlock. Software writes AAh and then 55h to a key register on consecutive clocks. This opens a short window in which exactly one write to the control byte may change those bits.

Two state machines form the block. The unlock machine has states LOCKED, ARMED and OPEN:
- LOCKED to ARMED on a key write of AAh.
- ARMED to OPEN on a key write of 55h in the very next clock.
- ARMED to ARMED on another AAh.
- ARMED to LOCKED on anything else.
- OPEN to LOCKED on a control-byte write, on a key write other than AAh, when the window runs out, or on a watchdog reset.
- OPEN to ARMED on a key write of AAh.

The timer machine has states COUNT, GRACE and FIRE:
- COUNT to GRACE on expiry.
- GRACE to COUNT on a restart, or at the end of the grace window while reset is disabled.
- GRACE to FIRE at the end of the grace window while reset is enabled.
- FIRE to COUNT unconditionally, one clock later.

Top module: `wdt_guard`

## Requirements
- R1: The control byte is read at address D8h as {baud-double (bit7), power-on flag (bit6), 0, 0, timeout flag (bit3), watchdog-reset flag (bit2), reset enable (bit1), restart (bit0, always reads 0)}. Any other address reads 00h.
- R2: A protected write is accepted only in the following sequence: AAh is written to the key register at C7h, then 55h is written there in the next clock, then the control byte is written within the following 3 clocks. One control-byte write consumes the window. A gap, a wrong value or a late write leaves the block locked.
- R3: Without the unlock, a control-byte write changes only bit7 and bit2. Bits 6, 3, 1 and 0 keep their values.
- R4: A protected write with bit0 = 1 clears the counter. Bit0 reads 0 afterwards.
- R5: The counter expires 2^(BASE_EXP + STEP_EXP*period_sel) clocks after a restart, and the timeout flag is set at that edge whether or not interrupts are enabled. With the defaults these periods are 2^17, 2^20, 2^23 and 2^26. If the count already exceeds a newly selected period, expiry follows at once.
- R6: wdt_irq is high exactly when the timeout flag is 1 and irq_en is 1.
- R7: Hardware never clears the timeout flag; only software (protected write) or a reset does.
- R8: Exactly 512 clocks after expiry, wdt_rst pulses high for one clock if the reset enable bit is 1. A restart inside that window cancels it. With reset enable 0 no pulse occurs, and counting restarts from zero.
- R9: After a watchdog reset pulse, the watchdog-reset flag is 1, the timeout flag and bit7 are 0, the unlock is closed and counting restarts. The power-on flag and reset enable keep their values.
- R10: A power-on reset (por_n low) makes the byte read 40h.
- R11: An external reset (ext_rst_n low) clears bit7 and the timeout flag, keeps bits 6, 2 and 1, and drops any pending watchdog reset.
- R12: After power-on, the power-on flag stays 1 until a protected write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset, active low, asynchronous |
| period_sel | input | 2 | Timeout interval select |
| irq_en | input | 1 | Watchdog interrupt enable |
| sfr_wr | input | 1 | Register write strobe |
| sfr_addr | input | 8 | Register address |
| sfr_wdata | input | 8 | Register write data |
| sfr_rdata | output | 8 | Register read data for sfr_addr |
| wdt_irq | output | 1 | Interrupt request |
| wdt_rst | output | 1 | One-clock watchdog reset pulse |

## Verification
The properties assume that sfr_addr and sfr_wdata are steady whenever sfr_wr is sampled high. They also assume that both resets are released away from the active edge, and that the ext_rst_n and por_n inputs are the only resets reaching the block. The stimulus therefore changes every input on the falling clock edge, and it lowers and raises the resets there too. It leaves period_sel unchanged while an expiry is being timed. The persistence properties exclude cycles with an unlocked control write, because only such a write may legally change the guarded bits.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        TM_COUNT = 2'd0,
        TM_GRACE = 2'd1,
        TM_FIRE  = 2'd2
    } tm_state_e;

    typedef enum logic [1:0] {
        UL_LOCKED = 2'd0,
        UL_ARMED  = 2'd1,
        UL_OPEN   = 2'd2
    } ul_state_e;

    localparam int BIT_BAUD    = 7;
    localparam int BIT_PORF    = 6;
    localparam int BIT_TOF     = 3;
    localparam int BIT_WRF     = 2;
    localparam int BIT_REN     = 1;
    localparam int BIT_RESTART = 0;

endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock #(
    parameter int          AW       = 8,
    parameter int          DW       = 8,
    parameter logic [AW-1:0] KEY_ADDR  = 8'hC7,
    parameter logic [AW-1:0] CTRL_ADDR = 8'hD8,
    parameter logic [DW-1:0] KEY_FIRST  = 8'hAA,
    parameter logic [DW-1:0] KEY_SECOND = 8'h55,
    parameter int          WIN      = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          relock,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          open_o
);
    import wdt_pkg::*;

    localparam int WCW = (WIN > 1) ? $clog2(WIN) : 1;

    ul_state_e       st, st_n;
    logic [WCW-1:0]  win, win_n;
    logic            key_wr, ctrl_wr;

    assign key_wr  = wr && (addr == KEY_ADDR);
    assign ctrl_wr = wr && (addr == CTRL_ADDR);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= UL_LOCKED;
            win <= '0;
        end else begin
            st  <= st_n;
            win <= win_n;
        end
    end

    // next state
    always_comb begin
        st_n  = st;
        win_n = win;
        unique case (st)
            UL_LOCKED: begin
                if (key_wr && wdata == KEY_FIRST)
                    st_n = UL_ARMED;
            end
            UL_ARMED: begin
                if (key_wr && wdata == KEY_SECOND) begin
                    st_n  = UL_OPEN;
                    win_n = '0;
                end else if (key_wr && wdata == KEY_FIRST) begin
                    st_n = UL_ARMED;
                end else begin
                    st_n = UL_LOCKED;
                end
            end
            UL_OPEN: begin
                if (ctrl_wr)
                    st_n = UL_LOCKED;
                else if (key_wr)
                    st_n = (wdata == KEY_FIRST) ? UL_ARMED : UL_LOCKED;
                else if (win == WCW'(WIN - 1))
                    st_n = UL_LOCKED;
                else
                    win_n = win + WCW'(1);
            end
            default: st_n = UL_LOCKED;
        endcase
        if (relock)
            st_n = UL_LOCKED;
    end

    // outputs
    always_comb begin
        open_o = (st == UL_OPEN);
    end

endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
    parameter int BASE_EXP = 17,
    parameter int STEP_EXP = 3,
    parameter int GRACE    = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       restart,
    input  logic       reset_en,
    output logic       expire,
    output logic       fire
);
    import wdt_pkg::*;

    localparam int NSEL = 4;
    localparam int CW   = BASE_EXP + STEP_EXP * (NSEL - 1) + 1;
    localparam int GW   = (GRACE > 1) ? $clog2(GRACE) : 1;

    tm_state_e      st, st_n;
    logic [CW-1:0]  cnt, cnt_n;
    logic [GW-1:0]  gcnt, gcnt_n;
    logic [CW-1:0]  lim_tab [NSEL];
    logic [CW-1:0]  lim;
    logic           at_limit;

    generate
        for (genvar g = 0; g < NSEL; g++) begin : g_lim
            assign lim_tab[g] = (CW'(1) << (BASE_EXP + STEP_EXP * g)) - CW'(1);
        end
    endgenerate

    assign lim      = lim_tab[sel];
    assign at_limit = (cnt >= lim);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= TM_COUNT;
            cnt  <= '0;
            gcnt <= '0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            gcnt <= gcnt_n;
        end
    end

    // next state
    always_comb begin
        st_n   = st;
        cnt_n  = cnt;
        gcnt_n = gcnt;
        unique case (st)
            TM_COUNT: begin
                if (restart) begin
                    cnt_n = '0;
                end else if (at_limit) begin
                    st_n   = TM_GRACE;
                    cnt_n  = '0;
                    gcnt_n = '0;
                end else begin
                    cnt_n = cnt + CW'(1);
                end
            end
            TM_GRACE: begin
                if (restart) begin
                    st_n  = TM_COUNT;
                    cnt_n = '0;
                end else if (gcnt == GW'(GRACE - 1)) begin
                    st_n  = reset_en ? TM_FIRE : TM_COUNT;
                    cnt_n = '0;
                end else begin
                    gcnt_n = gcnt + GW'(1);
                end
            end
            TM_FIRE: begin
                st_n  = TM_COUNT;
                cnt_n = '0;
            end
            default: begin
                st_n  = TM_COUNT;
                cnt_n = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        expire = (st == TM_COUNT) && !restart && at_limit;
        fire   = (st == TM_FIRE);
    end

endmodule

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_any_n,
    input  logic       wr_ctrl,
    input  logic       unlocked,
    input  logic [7:0] wdata,
    input  logic       expire,
    input  logic       fire,
    output logic       restart,
    output logic       baud,
    output logic       por_flag,
    output logic       tof,
    output logic       wrf,
    output logic       ren,
    output logic [7:0] byte_o
);
    import wdt_pkg::*;

    logic prot_wr;

    assign prot_wr = wr_ctrl && unlocked;
    assign restart = prot_wr && wdata[BIT_RESTART];

    // bits cleared by any reset
    always_ff @(posedge clk or negedge rst_any_n) begin
        if (!rst_any_n) begin
            baud <= 1'b0;
            tof  <= 1'b0;
        end else if (fire) begin
            baud <= 1'b0;
            tof  <= 1'b0;
        end else begin
            if (wr_ctrl)
                baud <= wdata[BIT_BAUD];
            if (expire)
                tof <= 1'b1;
            else if (prot_wr)
                tof <= wdata[BIT_TOF];
        end
    end

    // bits touched only by power-on reset
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            por_flag <= 1'b1;
            ren      <= 1'b0;
            wrf      <= 1'b0;
        end else begin
            if (prot_wr) begin
                por_flag <= wdata[BIT_PORF];
                ren      <= wdata[BIT_REN];
            end
            if (fire && ren)
                wrf <= 1'b1;
            else if (wr_ctrl)
                wrf <= wdata[BIT_WRF];
        end
    end

    always_comb begin
        byte_o = {baud, por_flag, 2'b00, tof, wrf, ren, 1'b0};
    end

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
    parameter int          BASE_EXP   = 17,
    parameter int          STEP_EXP   = 3,
    parameter int          GRACE      = 512,
    parameter int          WIN        = 3,
    parameter logic [7:0]  CTRL_ADDR  = 8'hD8,
    parameter logic [7:0]  KEY_ADDR   = 8'hC7,
    parameter logic [7:0]  KEY_FIRST  = 8'hAA,
    parameter logic [7:0]  KEY_SECOND = 8'h55
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       ext_rst_n,
    input  logic [1:0] period_sel,
    input  logic       irq_en,
    input  logic       sfr_wr,
    input  logic [7:0] sfr_addr,
    input  logic [7:0] sfr_wdata,
    output logic [7:0] sfr_rdata,
    output logic       wdt_irq,
    output logic       wdt_rst
);
    logic       rst_any_n;
    logic       ta_open;
    logic       restart, expire, fire;
    logic       baud, por_flag, tof, wrf, ren;
    logic       wr_ctrl;
    logic [7:0] ctrl_byte;

    assign rst_any_n = por_n & ext_rst_n;
    assign wr_ctrl   = sfr_wr && (sfr_addr == CTRL_ADDR);

    wdt_unlock #(
        .AW(8), .DW(8),
        .KEY_ADDR(KEY_ADDR), .CTRL_ADDR(CTRL_ADDR),
        .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND),
        .WIN(WIN)
    ) u_unlock (
        .clk    (clk),
        .rst_n  (rst_any_n),
        .relock (fire),
        .wr     (sfr_wr),
        .addr   (sfr_addr),
        .wdata  (sfr_wdata),
        .open_o (ta_open)
    );

    wdt_timer #(
        .BASE_EXP(BASE_EXP), .STEP_EXP(STEP_EXP), .GRACE(GRACE)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_any_n),
        .sel      (period_sel),
        .restart  (restart),
        .reset_en (ren),
        .expire   (expire),
        .fire     (fire)
    );

    wdt_ctrl_reg u_reg (
        .clk       (clk),
        .por_n     (por_n),
        .rst_any_n (rst_any_n),
        .wr_ctrl   (wr_ctrl),
        .unlocked  (ta_open),
        .wdata     (sfr_wdata),
        .expire    (expire),
        .fire      (fire),
        .restart   (restart),
        .baud      (baud),
        .por_flag  (por_flag),
        .tof       (tof),
        .wrf       (wrf),
        .ren       (ren),
        .byte_o    (ctrl_byte)
    );

    always_comb begin
        sfr_rdata = (sfr_addr == CTRL_ADDR) ? ctrl_byte : 8'h00;
        wdt_irq   = tof & irq_en;
        wdt_rst   = fire;
    end

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk #(
    parameter logic [7:0] CTRL_ADDR = 8'hD8
) (
    input logic       clk,
    input logic       por_n,
    input logic       ext_rst_n,
    input logic       sfr_wr,
    input logic [7:0] sfr_addr,
    input logic       irq_en,
    input logic       wdt_irq,
    input logic       wdt_rst,
    input logic       unlocked,
    input logic       ewt,
    input logic       wtrf,
    input logic       tflag,
    input logic       pflag
);
    logic prot_ctrl;
    assign prot_ctrl = unlocked && sfr_wr && (sfr_addr == CTRL_ADDR);

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!por_n || !ext_rst_n)
        !irq_en |-> !wdt_irq);  // R6

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n || !ext_rst_n)
        wdt_rst |=> !wdt_rst);  // R8

    AST_RST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!por_n || !ext_rst_n)
        wdt_rst |-> $past(ewt));  // R8

    AST_RST_SETS_FLAG: assert property (@(posedge clk) disable iff (!por_n || !ext_rst_n)
        wdt_rst |=> wtrf);  // R9

    AST_TFLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n || !ext_rst_n)
        (tflag && !prot_ctrl && !wdt_rst) |=> tflag);  // R7

    AST_ENABLE_GUARDED: assert property (@(posedge clk) disable iff (!por_n)
        !prot_ctrl |=> $stable(ewt));  // R3

    AST_PFLAG_HELD: assert property (@(posedge clk) disable iff (!por_n)
        (pflag && !prot_ctrl) |=> pflag);  // R12

endmodule

bind wdt_guard wdt_guard_chk #(.CTRL_ADDR(CTRL_ADDR)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .ext_rst_n (ext_rst_n),
    .sfr_wr    (sfr_wr),
    .sfr_addr  (sfr_addr),
    .irq_en    (irq_en),
    .wdt_irq   (wdt_irq),
    .wdt_rst   (wdt_rst),
    .unlocked  (ta_open),
    .ewt       (ren),
    .wtrf      (wrf),
    .tflag     (tof),
    .pflag     (por_flag)
);

// File: tb/wdt_guard_tb_top.sv
module wdt_guard_tb_top;

    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] A_CTRL = 8'hD8;
    localparam logic [7:0] A_KEY  = 8'hC7;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic [1:0] period_sel = 2'd3;
    logic       irq_en = 1'b0;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_addr = A_CTRL;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic       wdt_irq, wdt_rst;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_guard #(.BASE_EXP(4), .STEP_EXP(3), .GRACE(512)) dut_i (
        .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
        .period_sel(period_sel), .irq_en(irq_en),
        .sfr_wr(sfr_wr), .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata), .wdt_irq(wdt_irq), .wdt_rst(wdt_rst)
    );

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(posedge clk);
        #1;
        sfr_wr = 1'b0; sfr_addr = A_CTRL;
    endtask

    task automatic pwr(input logic [7:0] d);
        wr(A_KEY, 8'hAA);
        wr(A_KEY, 8'h55);
        wr(A_CTRL, d);
    endtask

    task automatic rd_at(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        sfr_addr = a;
        #1;
        v = sfr_rdata;
        sfr_addr = A_CTRL;
    endtask

    task automatic count_pulses(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (wdt_rst) c++;
        end
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        rd_at(A_CTRL, v); chk("R10 power-on value", v, 8'h40);
        rd_at(A_KEY, v);  chk("R1 other address reads zero", v, 8'h00);
        chk("R8 no reset pulse after power-on", {7'b0, wdt_rst}, 8'h00);
    endtask

    task automatic t_plain_writes();
        logic [7:0] v;
        wr(A_CTRL, 8'hFF);
        rd_at(A_CTRL, v); chk("R3 locked write touches bits 7 and 2 only", v, 8'hC4);
        wr(A_CTRL, 8'h00);
        rd_at(A_CTRL, v); chk("R12 power-on flag survives locked write", v, 8'h40);
    endtask

    task automatic t_unlock_ok();
        logic [7:0] v;
        pwr(8'h02);
        rd_at(A_CTRL, v); chk("R2 protected write accepted", v, 8'h02);
    endtask

    task automatic t_unlock_bad();
        logic [7:0] v;
        wr(A_KEY, 8'hAA); wr(A_KEY, 8'h11); wr(A_CTRL, 8'h00);
        rd_at(A_CTRL, v); chk("R2 wrong second key relocks", v, 8'h02);
        wr(A_KEY, 8'hAA); @(posedge clk); wr(A_KEY, 8'h55); wr(A_CTRL, 8'h00);
        rd_at(A_CTRL, v); chk("R2 gap between keys relocks", v, 8'h02);
        wr(A_KEY, 8'hAA); wr(A_KEY, 8'h55);
        repeat (3) @(posedge clk);
        wr(A_CTRL, 8'h00);
        rd_at(A_CTRL, v); chk("R2 write after window rejected", v, 8'h02);
        pwr(8'h0A); wr(A_CTRL, 8'h00);
        rd_at(A_CTRL, v); chk("R2 only one write per unlock", v, 8'h0A);
        wr(A_KEY, 8'hAA); wr(A_KEY, 8'h55);
        repeat (2) @(posedge clk);
        wr(A_CTRL, 8'h02);
        rd_at(A_CTRL, v); chk("R2 write on last window clock accepted", v, 8'h02);
    endtask

    task automatic t_expiry_and_fire();
        logic [7:0] v;
        period_sel = 2'd0;
        pwr(8'h03);
        repeat (15) @(posedge clk);
        rd_at(A_CTRL, v); chk("R5 no timeout one clock early", v & 8'h08, 8'h00);
        @(posedge clk);
        rd_at(A_CTRL, v); chk("R5 timeout flag at period", v & 8'h08, 8'h08);
        chk("R6 no irq while disabled", {7'b0, wdt_irq}, 8'h00);
        irq_en = 1'b1; #1;
        chk("R6 irq follows enable", {7'b0, wdt_irq}, 8'h01);
        repeat (511) @(posedge clk);
        rd_at(A_CTRL, v); chk("R7 flag still set in grace", v & 8'h08, 8'h08);
        chk("R8 no pulse before 512", {7'b0, wdt_rst}, 8'h00);
        @(posedge clk);
        @(negedge clk);
        chk("R8 pulse at 512 after expiry", {7'b0, wdt_rst}, 8'h01);
        @(posedge clk);
        rd_at(A_CTRL, v); chk("R9 flags after watchdog reset", v, 8'h06);
        chk("R8 pulse lasts one clock", {7'b0, wdt_rst}, 8'h00);
        irq_en = 1'b0;
    endtask

    task automatic t_cancel();
        logic [7:0] v;
        int c;
        pwr(8'h03);
        repeat (16) @(posedge clk);
        rd_at(A_CTRL, v); chk("R5 expiry before cancel", v & 8'h08, 8'h08);
        repeat (100) @(posedge clk);
        pwr(8'h0B);
        count_pulses(450, c);
        chk("R8 restart in grace cancels pulse", 8'(c), 8'h00);
        pwr(8'h01);
        rd_at(A_CTRL, v); chk("R4 restart bit reads zero, R7 flag cleared by software", v, 8'h00);
    endtask

    task automatic t_disabled();
        logic [7:0] v;
        int c;
        repeat (16) @(posedge clk);
        rd_at(A_CTRL, v); chk("R5 flag set with reset disabled", v & 8'h08, 8'h08);
        count_pulses(600, c);
        chk("R8 no pulse with reset disabled", 8'(c), 8'h00);
        rd_at(A_CTRL, v); chk("R8 watchdog flag untouched when disabled", v & 8'h04, 8'h00);
    endtask

    task automatic t_period1();
        logic [7:0] v;
        period_sel = 2'd1;
        pwr(8'h01);
        repeat (127) @(posedge clk);
        rd_at(A_CTRL, v); chk("R5 select 1 not yet expired", v & 8'h08, 8'h00);
        @(posedge clk);
        rd_at(A_CTRL, v); chk("R5 select 1 expires at 128", v & 8'h08, 8'h08);
    endtask

    task automatic t_external();
        logic [7:0] v;
        int c;
        period_sel = 2'd0;
        pwr(8'h43);
        wr(A_CTRL, 8'h84);
        repeat (20) @(posedge clk);
        rd_at(A_CTRL, v); chk("R11 state before external reset", v, 8'hCE);
        @(negedge clk); ext_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        ext_rst_n = 1'b1;
        rd_at(A_CTRL, v); chk("R11 external reset retention", v, 8'h46);
        count_pulses(515, c);
        chk("R11 pending reset dropped", 8'(c), 8'h00);
    endtask

    task automatic t_power_on();
        logic [7:0] v;
        @(negedge clk); por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        rd_at(A_CTRL, v); chk("R10 power-on clears all but power flag", v, 8'h40);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        t_reset_state();
        t_plain_writes();
        t_unlock_ok();
        t_unlock_bad();
        t_expiry_and_fire();
        t_cancel();
        t_disabled();
        t_period1();
        t_external();
        t_power_on();
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 20000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

endmodule